// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block moves a group of registers between a register file and a stack in memory. A single command gives an 8-bit selection mask, a direction (save to the stack or restore from it), a width select (full-word registers or byte registers), a bank select that chooses the lower or the upper group of eight registers, and the starting stack pointer. The block then handles one selected register per clock. Each step issues a register-file read together with a stack write, or a stack read together with a register-file write. When the list is finished the block reports the final stack pointer and raises a one-cycle done pulse.

Saving walks the mask from the most significant bit down to bit 0. Restoring walks it from bit 0 up to bit 7. A stack filled by a save is therefore emptied in the matching order by a restore with the same mask. Every register takes a two-byte stack slot, whatever its width. The register file and the memory are outside the block and are read combinationally: the data for an access is returned in the same cycle.

Top module: `regmask_stack_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0, sp_o is 0, and no register-file or memory enable is asserted.
- R2: The register index used for a mask bit b is {bank_hi_i, b[2:0]}: bank_hi_i=0 addresses registers 0..7 and bank_hi_i=1 addresses registers 8..15.
- R3: A save (dir_pop_i=0) handles the set mask bits from 7 down to 0. For each one the pointer first drops by 2, then rf_rd_en_o and mem_wr_en_o are asserted with mem_addr_o equal to the lowered pointer.
- R4: A restore (dir_pop_i=1) handles the set mask bits from 0 up to 7. For each one mem_rd_en_o and rf_wr_en_o are asserted with mem_addr_o equal to the current pointer, and the pointer then rises by 2.
- R5: With word_i=1, full 16-bit data is moved and rf_wr_word_o=1. With word_i=0, data is moved in bits 7:0 with bits 15:8 driven to zero on mem_wr_data_o and rf_wr_data_o, and rf_wr_word_o=0. In both cases the pointer moves by 2 per register.
- R6: Exactly one selected register is handled per busy cycle. Clear mask bits produce no access. Memory is never read and written in the same cycle, and there is no access while the block is idle.
- R7: With N set mask bits and the start sampled at clock edge 0, the accesses occur in the N cycles after edges 0..N-1, and done_o is high for exactly the cycle after edge N. An empty mask gives done_o after edge 0, with sp_o equal to the start pointer.
- R8: A start request while busy_o=1 is ignored: the running list completes unchanged and no extra accesses occur.
- R9: The stack pointer wraps modulo 2^16. After done_o, sp_o holds the final pointer until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command request, taken only when idle |
| mask_i | input | 8 | Register selection mask |
| dir_pop_i | input | 1 | 0 = save to stack, 1 = restore from stack |
| word_i | input | 1 | 1 = word registers, 0 = byte registers |
| bank_hi_i | input | 1 | 1 = registers 8..15, 0 = registers 0..7 |
| sp_i | input | 16 | Starting stack pointer |
| rf_rd_en_o | output | 1 | Register-file read strobe |
| rf_rd_idx_o | output | 4 | Register-file read index |
| rf_rd_data_i | input | 16 | Register-file read data (same cycle) |
| rf_wr_en_o | output | 1 | Register-file write strobe |
| rf_wr_idx_o | output | 4 | Register-file write index |
| rf_wr_word_o | output | 1 | Register-file write is full width |
| rf_wr_data_o | output | 16 | Register-file write data |
| mem_wr_en_o | output | 1 | Stack memory write strobe |
| mem_rd_en_o | output | 1 | Stack memory read strobe |
| mem_addr_o | output | 16 | Stack memory byte address |
| mem_wr_data_o | output | 16 | Stack memory write data |
| mem_rd_data_i | input | 16 | Stack memory read data (same cycle) |
| busy_o | output | 1 | A list is being processed |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Current or final stack pointer |

## Verification
The start is driven at a falling edge and sampled at the next rising edge, edge 0. The k-th access of a list is present in the cycle between edge k and edge k+1. The scoreboard monitor samples it at the falling edge in the middle of that cycle and compares it against the next queued item. The driver counts rising edges after the start and checks that done_o is low after each edge before edge N and high after edge N, where N is the number of set mask bits. At that same falling edge it checks the final pointer and confirms that the expected-access queue is empty.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

   typedef enum logic {
      DIR_SAVE    = 1'b0,
      DIR_RESTORE = 1'b1
   } stk_dir_e;

   // bytes occupied on the stack by one register, independent of its width
   function automatic int slot_bytes(input int data_w);
      return data_w / 8;
   endfunction

endpackage

// File: rtl/regstk_pick.sv
// Finds the index of the first set bit, scanning from the top or the bottom
module regstk_pick #(
   parameter int N          = 8,
   parameter bit HIGH_FIRST = 1'b0,
   localparam int IW        = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);

   generate
      if (N < 2) begin : g_bad
         $error("regstk_pick: N must be at least 2");
      end

      if (HIGH_FIRST) begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end else begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/regstk_fmt.sv
// Width formatter: word passes through, byte keeps the low half zero-extended
module regstk_fmt #(
   parameter int DW     = 16,
   localparam int BW    = DW / 2
) (
   input  logic [DW-1:0] d,
   input  logic          word,
   output logic [DW-1:0] q
);

   generate
      if (DW % 16 != 0) begin : g_bad
         $error("regstk_fmt: DW must be a multiple of 16");
      end
   endgenerate

   always_comb begin
      q = word ? d : {{(DW - BW){1'b0}}, d[BW-1:0]};
   end

endmodule

// File: rtl/regmask_stack_seq.sv
module regmask_stack_seq
   import regstk_pkg::*;
#(
   parameter int MASK_W = 8,
   parameter int DATA_W = 16,
   parameter int SP_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [MASK_W-1:0]          mask_i,
   input  logic                       dir_pop_i,
   input  logic                       word_i,
   input  logic                       bank_hi_i,
   input  logic [SP_W-1:0]            sp_i,
   output logic                       rf_rd_en_o,
   output logic [$clog2(MASK_W):0]    rf_rd_idx_o,
   input  logic [DATA_W-1:0]          rf_rd_data_i,
   output logic                       rf_wr_en_o,
   output logic [$clog2(MASK_W):0]    rf_wr_idx_o,
   output logic                       rf_wr_word_o,
   output logic [DATA_W-1:0]          rf_wr_data_o,
   output logic                       mem_wr_en_o,
   output logic                       mem_rd_en_o,
   output logic [SP_W-1:0]            mem_addr_o,
   output logic [DATA_W-1:0]          mem_wr_data_o,
   input  logic [DATA_W-1:0]          mem_rd_data_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [SP_W-1:0]            sp_o
);

   localparam int            BIT_W = $clog2(MASK_W);
   localparam logic [SP_W-1:0] STEP = SP_W'(slot_bytes(DATA_W));

   generate
      if (MASK_W < 2 || (MASK_W & (MASK_W - 1)) != 0) begin : g_bad_mask
         $error("regmask_stack_seq: MASK_W must be a power of two >= 2");
      end
      if (SP_W < 4) begin : g_bad_sp
         $error("regmask_stack_seq: SP_W too small");
      end
   endgenerate

   // command state
   logic              run_q;
   logic              done_q;
   logic [MASK_W-1:0] pend_q;
   stk_dir_e          dir_q;
   logic              word_q;
   logic              hi_q;
   logic [SP_W-1:0]   sp_q;

   // selection of the register handled this cycle
   logic [BIT_W-1:0]  top_idx;
   logic [BIT_W-1:0]  bot_idx;
   logic [BIT_W-1:0]  cur_idx;
   logic [MASK_W-1:0] cur_hot;
   logic [MASK_W-1:0] rest;

   regstk_pick #(.N(MASK_W), .HIGH_FIRST(1'b1)) u_pick_top (
      .vec (pend_q),
      .idx (top_idx)
   );

   regstk_pick #(.N(MASK_W), .HIGH_FIRST(1'b0)) u_pick_bot (
      .vec (pend_q),
      .idx (bot_idx)
   );

   always_comb begin
      cur_idx = (dir_q == DIR_RESTORE) ? bot_idx : top_idx;
      cur_hot = MASK_W'(1) << cur_idx;
      rest    = pend_q & ~cur_hot;
   end

   // access strobes and addressing
   logic [SP_W-1:0] sp_dec;
   logic [SP_W-1:0] sp_inc;

   always_comb begin
      sp_dec       = sp_q - STEP;
      sp_inc       = sp_q + STEP;
      mem_wr_en_o  = run_q && (dir_q == DIR_SAVE);
      mem_rd_en_o  = run_q && (dir_q == DIR_RESTORE);
      rf_rd_en_o   = mem_wr_en_o;
      rf_wr_en_o   = mem_rd_en_o;
      mem_addr_o   = (dir_q == DIR_RESTORE) ? sp_q : sp_dec;
      rf_rd_idx_o  = {hi_q, cur_idx};
      rf_wr_idx_o  = {hi_q, cur_idx};
      rf_wr_word_o = word_q;
   end

   regstk_fmt #(.DW(DATA_W)) u_fmt_save (
      .d    (rf_rd_data_i),
      .word (word_q),
      .q    (mem_wr_data_o)
   );

   regstk_fmt #(.DW(DATA_W)) u_fmt_restore (
      .d    (mem_rd_data_i),
      .word (word_q),
      .q    (rf_wr_data_o)
   );

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         pend_q <= '0;
         dir_q  <= DIR_SAVE;
         word_q <= 1'b0;
         hi_q   <= 1'b0;
         sp_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!run_q) begin
            if (start_i) begin
               dir_q  <= stk_dir_e'(dir_pop_i);
               word_q <= word_i;
               hi_q   <= bank_hi_i;
               sp_q   <= sp_i;
               pend_q <= mask_i;
               if (mask_i == '0) begin
                  done_q <= 1'b1;
               end else begin
                  run_q  <= 1'b1;
               end
            end
         end else begin
            pend_q <= rest;
            sp_q   <= (dir_q == DIR_RESTORE) ? sp_inc : sp_dec;
            if (rest == '0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o = run_q;
   assign done_o = done_q;
   assign sp_o   = sp_q;

   // checks beside the logic they guard
   a_r6_no_mixed_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr_en_o && mem_rd_en_o));

   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_wr_en_o && !mem_rd_en_o && !rf_wr_en_o && !rf_rd_en_o));

   a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en_o |=> (sp_o == SP_W'($past(sp_o) - STEP)));

   a_r4_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |=> (sp_o == SP_W'($past(sp_o) + STEP)));

   a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && mask_i == '0) |=>
         (done_o && !busy_o && sp_o == $past(sp_i)));

   a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(dir_q) && $stable(word_q) && $stable(hi_q)));

   a_r7_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: tb/regmask_stack_seq_bench.sv
module regmask_stack_seq_bench;

   typedef struct {
      bit          rd;
      logic [15:0] addr;
      logic [15:0] data;
      logic [3:0]  idx;
      bit          word;
   } acc_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  mask_i = '0;
   logic        dir_pop_i = 1'b0;
   logic        word_i = 1'b0;
   logic        bank_hi_i = 1'b0;
   logic [15:0] sp_i = '0;
   logic        rf_rd_en_o, rf_wr_en_o, rf_wr_word_o;
   logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
   logic [15:0] rf_rd_data_i, rf_wr_data_o;
   logic        mem_wr_en_o, mem_rd_en_o;
   logic [15:0] mem_addr_o, mem_wr_data_o, mem_rd_data_i;
   logic        busy_o, done_o;
   logic [15:0] sp_o;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;
   acc_t exp_q[$];

   always #10 clk = ~clk;

   function automatic logic [15:0] rf_pat(input logic [3:0] i);
      return {4'hB, i, 4'hC, i};
   endfunction

   function automatic logic [15:0] mem_pat(input logic [15:0] a);
      return a ^ 16'h5A3C;
   endfunction

   assign rf_rd_data_i  = rf_pat(rf_rd_idx_o);
   assign mem_rd_data_i = mem_pat(mem_addr_o);

   regmask_stack_seq u_regmask_stack_seq (
      .clk, .rst_n, .start_i, .mask_i, .dir_pop_i, .word_i, .bank_hi_i, .sp_i,
      .rf_rd_en_o, .rf_rd_idx_o, .rf_rd_data_i,
      .rf_wr_en_o, .rf_wr_idx_o, .rf_wr_word_o, .rf_wr_data_o,
      .mem_wr_en_o, .mem_rd_en_o, .mem_addr_o, .mem_wr_data_o, .mem_rd_data_i,
      .busy_o, .done_o, .sp_o
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // monitor: every access is compared with the head of the queue (R2..R6)
   always @(negedge clk) begin
      if (rst_n && (mem_wr_en_o || mem_rd_en_o || rf_wr_en_o || rf_rd_en_o)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected access", {15'd0, mem_wr_en_o, mem_addr_o}, 32'd0);
         end else begin
            acc_t e;
            bit   ok;
            e = exp_q.pop_front();
            if (e.rd) begin
               ok = mem_rd_en_o && !mem_wr_en_o && rf_wr_en_o && !rf_rd_en_o &&
                    mem_addr_o == e.addr && rf_wr_idx_o == e.idx &&
                    rf_wr_data_o == e.data && rf_wr_word_o == e.word;
               check(ok, "R4/R5", "restore access addr,idx,data",
                     {mem_addr_o, rf_wr_idx_o, rf_wr_word_o, 3'd0, rf_wr_data_o[7:0]},
                     {e.addr, e.idx, e.word, 3'd0, e.data[7:0]});
               check(rf_wr_data_o[15:8] == e.data[15:8], "R5", "restore upper data",
                     {16'd0, rf_wr_data_o}, {16'd0, e.data});
            end else begin
               ok = mem_wr_en_o && !mem_rd_en_o && rf_rd_en_o && !rf_wr_en_o &&
                    mem_addr_o == e.addr && rf_rd_idx_o == e.idx &&
                    mem_wr_data_o == e.data;
               check(ok, "R3/R2", "save access addr,idx",
                     {mem_addr_o, rf_rd_idx_o, 12'd0}, {e.addr, e.idx, 12'd0});
               check(mem_wr_data_o == e.data, "R5", "save data",
                     {16'd0, mem_wr_data_o}, {16'd0, e.data});
            end
         end
      end
   end

   // driver: queues the expected accesses, starts the list, times done
   task automatic run_list(input bit pop, input bit word, input bit hi,
                           input logic [7:0] mask, input logic [15:0] sp0,
                           input bit inject, input string req);
      logic [15:0] sp;
      int          n;
      sp = sp0;
      n  = 0;
      if (!pop) begin
         for (int b = 7; b >= 0; b--) begin
            if (mask[b]) begin
               acc_t e;
               sp     = sp - 16'd2;
               e.rd   = 1'b0;
               e.addr = sp;
               e.idx  = {hi, 3'(b)};
               e.data = word ? rf_pat(e.idx) : {8'h00, rf_pat(e.idx)[7:0]};
               e.word = word;
               exp_q.push_back(e);
               n++;
            end
         end
      end else begin
         for (int b = 0; b < 8; b++) begin
            if (mask[b]) begin
               acc_t e;
               e.rd   = 1'b1;
               e.addr = sp;
               e.idx  = {hi, 3'(b)};
               e.data = word ? mem_pat(sp) : {8'h00, mem_pat(sp)[7:0]};
               e.word = word;
               exp_q.push_back(e);
               sp     = sp + 16'd2;
               n++;
            end
         end
      end
      @(negedge clk);
      start_i   = 1'b1;
      mask_i    = mask;
      dir_pop_i = pop;
      word_i    = word;
      bank_hi_i = hi;
      sp_i      = sp0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k <= n; k++) begin
         if (inject && k == 0) begin
            start_i   = 1'b1;       // R8: request while busy
            mask_i    = 8'hFF;
            dir_pop_i = ~pop;
            sp_i      = 16'h7770;
         end else begin
            start_i = 1'b0;
         end
         if (k < n) begin
            check(!done_o && busy_o, "R7", "busy, no done before last edge",
                  {30'd0, busy_o, done_o}, 32'd2);
            @(posedge clk);
            @(negedge clk);
         end else begin
            check(done_o && !busy_o, req, "done pulse timing (R7)",
                  {30'd0, busy_o, done_o}, 32'd1);
            check(sp_o == sp, req, "final pointer", {16'd0, sp_o}, {16'd0, sp});
            check(exp_q.size() == 0, "R6", "all accesses seen",
                  exp_q.size(), 32'd0);
         end
      end
      start_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "R7", "watchdog expired", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(!busy_o && !done_o && sp_o == 16'h0 && !mem_wr_en_o && !mem_rd_en_o &&
            !rf_wr_en_o && !rf_rd_en_o, "R1", "reset state",
            {14'd0, busy_o, done_o, sp_o}, 32'd0);

      run_list(1'b0, 1'b1, 1'b0, 8'hA5, 16'h0100, 1'b0, "R3");
      run_list(1'b1, 1'b1, 1'b0, 8'hA5, 16'h00F8, 1'b0, "R4");
      run_list(1'b0, 1'b0, 1'b1, 8'h3C, 16'h0200, 1'b0, "R5");
      run_list(1'b1, 1'b0, 1'b1, 8'hC3, 16'h0300, 1'b0, "R5");
      run_list(1'b0, 1'b1, 1'b1, 8'h00, 16'h1234, 1'b0, "R7");
      run_list(1'b1, 1'b0, 1'b0, 8'h00, 16'h4320, 1'b0, "R7");
      run_list(1'b0, 1'b1, 1'b1, 8'hFF, 16'h0400, 1'b1, "R8");
      run_list(1'b1, 1'b1, 1'b0, 8'h81, 16'h0500, 1'b1, "R8");
      run_list(1'b0, 1'b1, 1'b0, 8'h07, 16'h0004, 1'b0, "R9");
      run_list(1'b1, 1'b0, 1'b1, 8'h0F, 16'hFFFC, 1'b0, "R9");
      run_list(1'b0, 1'b0, 1'b0, 8'h10, 16'h0010, 1'b0, "R2");

      // R9: pointer held after done, idle and quiet
      repeat (3) @(negedge clk);
      check(sp_o == 16'h000E && !busy_o && !done_o, "R9", "pointer held after done",
            {14'd0, busy_o, done_o, sp_o}, {16'd0, 16'h000E});
      finish_run();
   end

endmodule